// File: doc/BRIEF.md
# Program-Mode Address and Erase Controller

This block sits on the target side of a small flash microcontroller while the part is being programmed. A serial front end, which is not part of this block, decodes host commands and presents each one as a single-cycle request. The block keeps the word address (an 11-bit counter) and sorts each address into a memory region. It performs reads, single-word writes and bulk erases on an internal word-array model of the flash. It also holds the 12-bit configuration word, whose two protection bits control what reads can see and what an erase removes.

A mode-entry pulse places the counter on the configuration word at 0x7FF. The configuration word can be reached only until the first increment. The increment wraps from 0x7FF to 0x000. A bulk erase covers a different set of regions depending on where the counter sits and on the data-protect bit.

The sequencer has four states:
- `ST_IDLE` accepts commands.
- `ST_READ` lasts one cycle while the array output is gated into `rd_data`.
- `ST_WRITE` and `ST_ERASE` count down a parameterised busy time.

The transitions are:
- `ST_IDLE`→`ST_READ` on a read.
- `ST_IDLE`→`ST_WRITE` on a write.
- `ST_IDLE`→`ST_ERASE` on an erase.
- `ST_READ`→`ST_IDLE` after one cycle.
- `ST_WRITE`/`ST_ERASE`→`ST_IDLE` when the countdown reaches zero.
- Any state→`ST_IDLE` on mode entry.

Top module: `pgm_addr_ctrl`

## Requirements
- R1: After reset, and on the clock edge that samples `mode_enter` high, `pc` becomes 0x7FF, `busy` is low and the configuration word is reachable at that address.
- R2: Once an increment has been accepted, address 0x7FF reads 0xFFF and ignores writes until the next mode entry. While the word is reachable, a write stores the data with bits 11:10 forced to 1, and a read returns the stored word.
- R3: An accepted increment raises `pc` by one, and 0x7FF wraps to 0x000.
- R4: `cmd_op` is decoded as 0 no-op, 1 increment, 2 write, 3 read, 4 bulk erase; codes 5 to 7 do nothing. A read accepted at edge E0 raises `rd_valid` for exactly one cycle after edge E0+1, with `busy` high in between.
- R5: Array words that have never been written or that have been erased read 0xFFF. Addresses 0x448–0x7FE always read 0xFFF and ignore writes.
- R6: With configuration bit 4 at 0, reads of 0x040–0x3FE return 0x000, while 0x000–0x03F and 0x3FF still return their contents.
- R7: With configuration bit 7 at 0, reads of 0x400–0x43F return 0x000. User IDs (0x440–0x443), backup calibration (0x444–0x447) and the configuration word read and write normally whatever the protection bits hold.
- R8: A bulk erase with `pc` in 0x440–0x447 erases only the user ID and backup calibration words.
- R9: A bulk erase with `pc` in 0x400–0x43F and configuration bit 7 at 1 erases only the data flash words.
- R10: Any other bulk erase erases user memory and sets the configuration word to 0xFFF. It also erases data flash when configuration bit 7 was 0.
- R11: A write keeps `busy` high for `WRITE_CYCLES` cycles and an erase for `ERASE_CYCLES` cycles. Commands presented while `busy` is high are ignored.
- R12: A mode-entry pulse cancels a running busy period or a pending read; a command in the same cycle as the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_enter | input | 1 | One-cycle program-mode entry pulse |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command code |
| wr_data | input | 12 | Word to write |
| pc | output | 11 | Current word address |
| busy | output | 1 | High while a command is in progress |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 12 | Read result after protection gating |

## Verification
The reference model is run against a pattern of distinct words written at each region boundary: 0x000, 0x03F, 0x040, 0x3FE, 0x3FF, 0x400, 0x43F, 0x440, 0x444 and 0x447. This pattern separates an off-by-one in the region decode from a wrong protection window. The same words are read back under all four combinations of the two protection bits. Bulk erase is tried from the counter positions 0x7FF, 0x100, 0x400 and 0x440, each with the data-protect bit at 0 or 1, so each erase mapping leaves a different set of survivors. Increments and a mode-entry pulse are also issued inside busy windows, which tells apart ignoring a command, queuing it, and cancelling the running operation.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int PGA_ADDR_W = 11;
    localparam int PGA_DATA_W = 12;

    localparam logic [PGA_ADDR_W-1:0] USER_LAST  = 11'h3FF;
    localparam logic [PGA_ADDR_W-1:0] DATA_LAST  = 11'h43F;
    localparam logic [PGA_ADDR_W-1:0] UID_LAST   = 11'h443;
    localparam logic [PGA_ADDR_W-1:0] CAL_LAST   = 11'h447;
    localparam logic [PGA_ADDR_W-1:0] RSVD_LAST  = 11'h49F;
    localparam logic [PGA_ADDR_W-1:0] CFG_ADDR   = 11'h7FF;
    localparam logic [PGA_ADDR_W-1:0] OPEN_LAST  = 11'h03F;
    localparam logic [PGA_ADDR_W-1:0] PROT_LAST  = 11'h3FE;
    localparam int ARRAY_WORDS = int'(CAL_LAST) + 1;

    localparam int CP_BIT = 4;
    localparam int DP_BIT = 7;
    localparam logic [PGA_DATA_W-1:0] CFG_FIXED = 12'hC00;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_INC   = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_ERASE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        RG_USER, RG_DATA, RG_UID, RG_CAL, RG_RSVD, RG_CFG, RG_NONE
    } region_e;

    typedef struct packed {
        logic user;
        logic data;
        logic uid;
        logic cal;
        logic cfg;
    } erase_mask_t;

    function automatic region_e region_of(input logic [PGA_ADDR_W-1:0] a,
                                          input logic cfg_open);
        region_e r;
        if (a <= USER_LAST)                r = RG_USER;
        else if (a <= DATA_LAST)           r = RG_DATA;
        else if (a <= UID_LAST)            r = RG_UID;
        else if (a <= CAL_LAST)            r = RG_CAL;
        else if (a <= RSVD_LAST)           r = RG_RSVD;
        else if (a == CFG_ADDR && cfg_open) r = RG_CFG;
        else                               r = RG_NONE;
        return r;
    endfunction

endpackage

// File: rtl/pga_region_decode.sv
module pga_region_decode
    import pga_pkg::*;
(
    input  logic [PGA_ADDR_W-1:0] addr,
    input  logic                  cfg_open,
    output region_e               region,
    output logic                  in_array,
    output logic                  prot_window
);
    always_comb begin
        region      = region_of(addr, cfg_open);
        in_array    = (region == RG_USER) || (region == RG_DATA) ||
                      (region == RG_UID)  || (region == RG_CAL);
        prot_window = (addr > OPEN_LAST) && (addr <= PROT_LAST);
    end
endmodule

// File: rtl/pga_erase_plan.sv
module pga_erase_plan
    import pga_pkg::*;
(
    input  region_e     region,
    input  logic        dp_off,
    output erase_mask_t mask
);
    always_comb begin
        mask = '0;
        if (region == RG_UID || region == RG_CAL) begin
            mask.uid = 1'b1;
            mask.cal = 1'b1;
        end else if (region == RG_DATA && dp_off) begin
            mask.data = 1'b1;
        end else begin
            mask.user = 1'b1;
            mask.cfg  = 1'b1;
            mask.data = ~dp_off;
        end
    end
endmodule

// File: rtl/pga_word_array.sv
module pga_word_array
    import pga_pkg::*;
#(
    parameter int DEPTH  = ARRAY_WORDS,
    parameter int DATA_W = PGA_DATA_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              er_en,
    input  erase_mask_t       er_mask,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  filled;

    function automatic logic word_hit(input int idx, input erase_mask_t m);
        region_e r;
        r = region_of(PGA_ADDR_W'(idx), 1'b0);
        return (r == RG_USER && m.user) || (r == RG_DATA && m.data) ||
               (r == RG_UID  && m.uid)  || (r == RG_CAL  && m.cal);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
        end else begin
            if (er_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (word_hit(i, er_mask)) filled[i] <= 1'b0;
                end
            end
            if (wr_en) filled[addr] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '1;
        else if (rd_en) rdata <= filled[addr] ? mem[addr] : '1;
    end
endmodule

// File: rtl/pgm_addr_ctrl.sv
module pgm_addr_ctrl
    import pga_pkg::*;
#(
    parameter int WRITE_CYCLES = 4,
    parameter int ERASE_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_enter,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [PGA_DATA_W-1:0] wr_data,
    output logic [PGA_ADDR_W-1:0] pc,
    output logic                  busy,
    output logic                  rd_valid,
    output logic [PGA_DATA_W-1:0] rd_data
);
    localparam int MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int ARR_AW  = $clog2(ARRAY_WORDS);

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_ERASE} state_e;

    state_e                state_q, state_d;
    logic [PGA_ADDR_W-1:0] pc_q;
    logic [PGA_DATA_W-1:0] cfg_word;
    logic                  cfg_open;
    logic [CNT_W-1:0]      cnt_q;

    region_e               region;
    logic                  in_array, prot_window;
    erase_mask_t           er_mask;
    logic [PGA_DATA_W-1:0] arr_q, rd_src;

    logic accept, go_inc, go_write, go_read, go_erase;

    assign accept   = !mode_enter && (state_q == ST_IDLE) && cmd_valid;
    assign go_inc   = accept && (cmd_op == OP_INC);
    assign go_write = accept && (cmd_op == OP_WRITE);
    assign go_read  = accept && (cmd_op == OP_READ);
    assign go_erase = accept && (cmd_op == OP_ERASE);

    pga_region_decode u_dec (
        .addr        (pc_q),
        .cfg_open    (cfg_open),
        .region      (region),
        .in_array    (in_array),
        .prot_window (prot_window)
    );

    pga_erase_plan u_plan (
        .region (region),
        .dp_off (cfg_word[DP_BIT]),
        .mask   (er_mask)
    );

    pga_word_array #(.DEPTH(ARRAY_WORDS), .DATA_W(PGA_DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (go_read && in_array),
        .wr_en   (go_write && in_array),
        .er_en   (go_erase),
        .er_mask (er_mask),
        .addr    (pc_q[ARR_AW-1:0]),
        .wdata   (wr_data),
        .rdata   (arr_q)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_read)       state_d = ST_READ;
                else if (go_write) state_d = ST_WRITE;
                else if (go_erase) state_d = ST_ERASE;
            end
            ST_READ:  state_d = ST_IDLE;
            ST_WRITE: if (cnt_q == '0) state_d = ST_IDLE;
            ST_ERASE: if (cnt_q == '0) state_d = ST_IDLE;
        endcase
        if (mode_enter) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address, configuration word and busy timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= CFG_ADDR;
            cfg_open <= 1'b1;
            cfg_word <= '1;
            cnt_q    <= '0;
        end else if (mode_enter) begin
            pc_q     <= CFG_ADDR;
            cfg_open <= 1'b1;
            cnt_q    <= '0;
        end else begin
            if (go_inc) begin
                pc_q     <= pc_q + 1'b1;
                cfg_open <= 1'b0;
            end
            if (go_write && region == RG_CFG) cfg_word <= wr_data | CFG_FIXED;
            if (go_erase && er_mask.cfg)      cfg_word <= '1;
            if (go_write)                     cnt_q <= CNT_W'(WRITE_CYCLES - 1);
            else if (go_erase)                cnt_q <= CNT_W'(ERASE_CYCLES - 1);
            else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
        end
    end

    // read gating
    always_comb begin
        rd_src = '1;
        if (region == RG_CFG)  rd_src = cfg_word;
        else if (in_array)     rd_src = arr_q;
        if ((prot_window && !cfg_word[CP_BIT]) ||
            (region == RG_DATA && !cfg_word[DP_BIT]))
            rd_src = '0;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state_q == ST_READ) && !mode_enter;
            if (state_q == ST_READ && !mode_enter) rd_data <= rd_src;
        end
    end

    assign pc   = pc_q;
    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pga_checker.sv
module pga_checker
    import pga_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mode_enter,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic [PGA_ADDR_W-1:0] pc,
    input logic                  busy,
    input logic                  rd_valid,
    input logic [PGA_DATA_W-1:0] rd_data,
    input logic                  cfg_open,
    input logic [PGA_DATA_W-1:0] cfg_word
);
    logic inc_taken, erase_taken;
    assign inc_taken   = !busy && !mode_enter && cmd_valid && (cmd_op == OP_INC);
    assign erase_taken = !busy && !mode_enter && cmd_valid && (cmd_op == OP_ERASE);

    AST_ENTRY_PC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_enter |=> (pc == CFG_ADDR) && cfg_open && !busy); // R1

    AST_CFG_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        inc_taken |=> !cfg_open); // R2

    AST_CFG_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && pc == CFG_ADDR && !cfg_open) |-> rd_data == '1); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_taken |=> pc == $past(pc) + 1'b1); // R3

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4

    AST_USER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && pc > OPEN_LAST && pc <= PROT_LAST && !cfg_word[CP_BIT])
        |-> rd_data == '0); // R6

    AST_DATA_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && pc > USER_LAST && pc <= DATA_LAST && !cfg_word[DP_BIT])
        |-> rd_data == '0); // R7

    AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_taken |=> busy); // R11

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_enter) |=> $stable(pc)); // R11
endmodule

bind pgm_addr_ctrl pga_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_enter (mode_enter),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .pc         (pc),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .cfg_open   (cfg_open),
    .cfg_word   (cfg_word)
);

// File: tb/pgm_addr_ctrl_tb.sv
module pgm_addr_ctrl_tb;
    localparam int WC = 4;
    localparam int EC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_enter = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [11:0] wr_data = 12'h0;
    logic [10:0] pc;
    logic        busy, rd_valid;
    logic [11:0] rd_data;

    always #10 clk = ~clk;

    pgm_addr_ctrl #(.WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .wr_data(wr_data), .pc(pc), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    logic [11:0] m_mem [0:1095];
    bit          m_full [0:1095];
    int          m_pc;
    bit          m_open;
    logic [11:0] m_cfg;
    int          m_busy;
    bit          m_pend;
    logic [11:0] m_pend_val;
    bit          exp_rdv;
    logic [11:0] exp_rd;

    function automatic logic [11:0] model_read(int a);
        logic [11:0] v;
        v = 12'hFFF;
        if (a <= 16'h447) v = m_full[a] ? m_mem[a] : 12'hFFF;
        else if (a == 16'h7FF && m_open) v = m_cfg;
        if (a >= 16'h040 && a <= 16'h3FE && !m_cfg[4]) v = 12'h000;
        if (a >= 16'h400 && a <= 16'h43F && !m_cfg[7]) v = 12'h000;
        return v;
    endfunction

    task automatic model_erase();
        bit dp;
        dp = m_cfg[7];
        if (m_pc >= 16'h440 && m_pc <= 16'h447) begin
            for (int i = 16'h440; i <= 16'h447; i++) m_full[i] = 0;
        end else if (m_pc >= 16'h400 && m_pc <= 16'h43F && dp) begin
            for (int i = 16'h400; i <= 16'h43F; i++) m_full[i] = 0;
        end else begin
            for (int i = 0; i <= 16'h3FF; i++) m_full[i] = 0;
            if (!dp) for (int i = 16'h400; i <= 16'h43F; i++) m_full[i] = 0;
            m_cfg = 12'hFFF;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1096; i++) m_full[i] = 0;
            m_pc = 16'h7FF; m_open = 1; m_cfg = 12'hFFF;
            m_busy = 0; m_pend = 0; exp_rdv = 0; exp_rd = 12'h0;
        end else begin
            exp_rdv = 0;
            if (mode_enter) begin
                m_pc = 16'h7FF; m_open = 1; m_busy = 0; m_pend = 0;
            end else if (m_pend) begin
                exp_rdv = 1; exp_rd = m_pend_val; m_pend = 0;
            end else if (m_busy > 0) begin
                m_busy--;
            end else if (cmd_valid) begin
                case (cmd_op)
                    3'd1: begin m_pc = (m_pc + 1) & 16'h7FF; m_open = 0; end
                    3'd2: begin
                        if (m_pc <= 16'h447) begin m_mem[m_pc] = wr_data; m_full[m_pc] = 1; end
                        else if (m_pc == 16'h7FF && m_open) m_cfg = wr_data | 12'hC00;
                        m_busy = WC;
                    end
                    3'd3: begin m_pend_val = model_read(m_pc); m_pend = 1; end
                    3'd4: begin model_erase(); m_busy = EC; end
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit eb;
            eb = (m_busy > 0) || m_pend;
            vectors++;
            if (pc !== m_pc[10:0]) begin
                fails++; $display("FAIL %s pc: actual %h expected %h", cur_req, pc, m_pc[10:0]);
            end
            if (busy !== eb) begin
                fails++; $display("FAIL %s busy: actual %b expected %b (pc %h)", cur_req, busy, eb, pc);
            end
            if (rd_valid !== exp_rdv) begin
                fails++; $display("FAIL %s rd_valid: actual %b expected %b (pc %h)", cur_req, rd_valid, exp_rdv, pc);
            end else if (exp_rdv && rd_data !== exp_rd) begin
                fails++; $display("FAIL %s rd_data at %h: actual %h expected %h", cur_req, pc, rd_data, exp_rd);
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [11:0] d);
        cmd_valid = 1; cmd_op = op; wr_data = d;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 3'd0;
        while (busy) @(negedge clk);
    endtask

    task automatic enter();
        mode_enter = 1;
        @(negedge clk);
        mode_enter = 0;
    endtask

    task automatic go_to(input logic [10:0] a);
        while (pc !== a) issue(3'd1, 12'h0);
    endtask

    localparam int NA = 10;
    logic [10:0] addrs [NA] = '{11'h000, 11'h03F, 11'h040, 11'h3FE, 11'h3FF,
                                11'h400, 11'h43F, 11'h440, 11'h444, 11'h447};

    task automatic write_all(input logic [11:0] seed);
        for (int i = 0; i < NA; i++) begin
            go_to(addrs[i]);
            issue(3'd2, seed + 12'(i * 12'h111));
        end
    endtask

    task automatic read_all();
        for (int i = 0; i < NA; i++) begin
            go_to(addrs[i]);
            issue(3'd3, 12'h0);
        end
    endtask

    task automatic set_cfg(input logic [11:0] v);
        enter();
        issue(3'd2, v);
        issue(3'd3, 12'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL %s watchdog: actual no completion expected completion", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (pc !== 11'h7FF || busy !== 1'b0 || rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual pc %h busy %b rdv %b expected 7ff 0 0", pc, busy, rd_valid);
        end
        rst_n = 1;
        @(negedge clk);

        cur_req = "R1"; enter(); issue(3'd3, 12'h0);
        cur_req = "R2"; issue(3'd2, 12'h2D5); issue(3'd3, 12'h0);
        cur_req = "R3"; issue(3'd1, 12'h0);
        cur_req = "R5"; issue(3'd3, 12'h0);
        cur_req = "R4"; issue(3'd2, 12'h123); issue(3'd3, 12'h0);
        issue(3'd7, 12'h0); issue(3'd5, 12'h0); issue(3'd0, 12'h0); issue(3'd3, 12'h0);

        cur_req = "R5"; write_all(12'h101); read_all();
        go_to(11'h448); issue(3'd2, 12'hABC); issue(3'd3, 12'h0);
        go_to(11'h600); issue(3'd2, 12'h321); issue(3'd3, 12'h0);
        cur_req = "R2"; go_to(11'h7FF); issue(3'd3, 12'h0); issue(3'd2, 12'h000); issue(3'd3, 12'h0);
        cur_req = "R3"; issue(3'd1, 12'h0);

        cur_req = "R6"; set_cfg(12'h0C5); read_all();
        cur_req = "R7"; set_cfg(12'h055); read_all();
        go_to(11'h441); issue(3'd2, 12'h5A5); issue(3'd3, 12'h0);
        enter(); issue(3'd3, 12'h0);

        cur_req = "R9"; set_cfg(12'h0FF); go_to(11'h400);
        // R11: increments presented during the erase busy window are dropped
        cmd_valid = 1; cmd_op = 3'd4;
        @(negedge clk);
        cmd_op = 3'd1;
        repeat (3) @(negedge clk);
        cmd_valid = 0; cmd_op = 3'd0;
        cur_req = "R11";
        while (busy) @(negedge clk);
        cur_req = "R9"; read_all();

        cur_req = "R8"; write_all(12'h202); go_to(11'h440); issue(3'd4, 12'h0); read_all();

        cur_req = "R10"; write_all(12'h303);
        set_cfg(12'h07F); issue(3'd4, 12'h0); issue(3'd3, 12'h0);
        issue(3'd1, 12'h0); read_all();
        write_all(12'h404); set_cfg(12'h0FF); issue(3'd1, 12'h0);
        go_to(11'h100); issue(3'd4, 12'h0); read_all();
        enter(); issue(3'd3, 12'h0);

        cur_req = "R12";
        issue(3'd1, 12'h0); go_to(11'h010);
        cmd_valid = 1; cmd_op = 3'd4;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 3'd0;
        @(negedge clk);
        mode_enter = 1; cmd_valid = 1; cmd_op = 3'd1;
        @(negedge clk);
        mode_enter = 0; cmd_valid = 0; cmd_op = 3'd0;
        @(negedge clk);
        issue(3'd1, 12'h0); issue(3'd1, 12'h0);
        cmd_valid = 1; cmd_op = 3'd3;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 3'd0; mode_enter = 1;
        @(negedge clk);
        mode_enter = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule